// File: doc/BRIEF.md
# Tape Read Character-to-Word Assembler

This block takes one tape record, delivered one byte per handshake, and packs it into 24-bit memory words. Each finished word goes out on a write port at a running 15-bit address. The transfer ends when the word budget runs out or when the record ends, whichever comes first. A transfer is armed by a start pulse. The pulse carries the first address, the number of words allowed, the recording density and the binary/BCD choice. Two densities are supported: seven-track, where four 6-bit characters with a parity bit make a word, and nine-track, where three 8-bit bytes make a word.

On a seven-track read, every character has its parity checked against the sense chosen by the binary/BCD setting. A word cut short by the end of the record is padded with the fill character 074 (octal). In BCD mode, a record that runs out before the word budget adds one whole fill word. At termination the block raises a one-cycle done pulse and shows the next free address. It keeps sticky flags for parity failure, long block, fill word and tape mark.

A beat flagged as a mark stands for a zero-length record. It ends the transfer with nothing written.

Top module: `tape_word_asm`

## Requirements
- R1: Seven-track packing: byte bits [5:0] of successive characters land at word bits [23:18], [17:12], [11:6], [5:0] in arrival order. Byte bit 6 is the parity bit and bit 7 is ignored.
- R2: Seven-track parity is checked over byte bits [6:0]. Binary mode expects an odd count of ones and BCD mode an even count. On a failure the parity flag is set, the partly built word is dropped, the rest of the record is consumed without writes, and the transfer terminates.
- R3: Nine-track packing: successive bytes land at word bits [23:16], [15:8], [7:0]. No parity check is made.
- R4: When a seven-track record ends partway through a word, every character slot not yet filled holds 074 octal (6'b111100).
- R5: When a nine-track record ends after one byte of a word, bits [15:0] hold 16'h0F3C. When it ends after two bytes, bits [7:0] hold 8'h3C.
- R6: Each stored word goes to the current address. The address then advances by one modulo 2^15 and the remaining count drops by one.
- R7: A transfer ends when the count reaches zero or the record is exhausted. At that point done pulses for exactly one cycle, busy is low, the terminate flag is set, and xfer_addr shows the address after the last word written.
- R8: When the count reaches zero while record bytes remain, the long-block flag is set. The remaining bytes are consumed with no writes.
- R9: In BCD mode, when the record is exhausted with count still nonzero, one extra word 24'hF3CF3C (octal 74747474) is written at the next address. The fill flag is set, and done pulses in the cycle of that write.
- R10: A beat with in_mark high ends the transfer with the mark flag set and no word written.
- R11: A start pulse while busy is ignored. in_ready is low whenever the block is idle.
- R12: After reset busy, done, wr_en and all status flags are low. An accepted start clears every status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Arm a transfer (taken when idle) |
| cfg_bcd | input | 1 | 1 = BCD, 0 = binary |
| cfg_nine | input | 1 | 1 = nine-track, 0 = seven-track |
| cfg_addr | input | AW | First word address |
| cfg_count | input | CW | Word budget |
| in_valid | input | 1 | Record beat valid |
| in_ready | output | 1 | Record beat accepted |
| in_data | input | 8 | Record byte |
| in_last | input | 1 | Final beat of the record |
| in_mark | input | 1 | Beat stands for an empty record |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | AW | Word write address |
| wr_data | output | 24 | Word write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle termination pulse |
| xfer_addr | output | AW | Next address after the transfer |
| st_term | output | 1 | Terminated flag |
| st_parity | output | 1 | Parity failure flag |
| st_long | output | 1 | Long block flag |
| st_fill | output | 1 | Fill word written flag |
| st_mark | output | 1 | Tape mark flag |

## Verification
The checker watches several properties on every cycle:
- done lasts one cycle and never coincides with busy;
- in_ready stays low while idle;
- writes occur only during a transfer, and back-to-back writes step the address by one with wraparound;
- the fill flag rises together with a write of the fill pattern;
- the mark flag rises with no write.

Only the bench's scenarios can show the rest:
- character placement and padding per density;
- the two parity senses;
- the long-block drain;
- the BCD fill word at exact and short record ends;
- the start pulse ignored mid-transfer.

Each of these is compared word by word against a queue of expected writes.

// File: rtl/tape_asm_pkg.sv
package tape_asm_pkg;
    localparam int WORD_W = 24;
    localparam logic [WORD_W-1:0] PAD7_INIT  = 24'hF3CF3C;
    localparam logic [WORD_W-1:0] PAD9_INIT  = 24'h000F3C;
    localparam logic [WORD_W-1:0] FILL_WORD  = 24'hF3CF3C;
    localparam logic [1:0]        LAST_SLOT7 = 2'd3;
    localparam logic [1:0]        LAST_SLOT9 = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PACK  = 2'd1,
        ST_FILL  = 2'd2,
        ST_DRAIN = 2'd3
    } asm_state_e;
endpackage

// File: rtl/tape_asm_parity.sv
module tape_asm_parity (
    input  logic [6:0] frame_i,
    input  logic       even_i,
    output logic       ok_o
);
    // even_i: BCD sense (even ones); otherwise odd ones expected
    always_comb begin
        ok_o = even_i ? ~(^frame_i) : (^frame_i);
    end
endmodule

// File: rtl/tape_asm_merge.sv
module tape_asm_merge
    import tape_asm_pkg::*;
(
    input  logic [WORD_W-1:0] acc_i,
    input  logic [7:0]        byte_i,
    input  logic              nine_i,
    input  logic [1:0]        slot_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        word_o = acc_i;
        if (nine_i) begin
            case (slot_i)
                2'd0:    word_o[23:16] = byte_i;
                2'd1:    word_o[15:8]  = byte_i;
                default: word_o[7:0]   = byte_i;
            endcase
        end else begin
            case (slot_i)
                2'd0:    word_o[23:18] = byte_i[5:0];
                2'd1:    word_o[17:12] = byte_i[5:0];
                2'd2:    word_o[11:6]  = byte_i[5:0];
                default: word_o[5:0]   = byte_i[5:0];
            endcase
        end
    end
endmodule

// File: rtl/tape_word_asm.sv
module tape_word_asm
    import tape_asm_pkg::*;
#(
    parameter int AW = 15,
    parameter int CW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_bcd,
    input  logic              cfg_nine,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CW-1:0]     cfg_count,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_mark,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     xfer_addr,
    output logic              st_term,
    output logic              st_parity,
    output logic              st_long,
    output logic              st_fill,
    output logic              st_mark
);
    typedef struct packed {
        asm_state_e        st;
        logic [AW-1:0]     addr;
        logic [CW-1:0]     cnt;
        logic [1:0]        slot;
        logic [WORD_W-1:0] acc;
        logic              bcd;
        logic              nine;
        logic              wr_en;
        logic [AW-1:0]     wr_addr;
        logic [WORD_W-1:0] wr_data;
        logic              done;
        logic              term;
        logic              par;
        logic              lng;
        logic              fill;
        logic              mark;
    } asm_regs_t;

    asm_regs_t         r_q, r_d;
    logic              par_ok;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] pad_init;
    logic [1:0]        last_slot;
    logic              word_end;

    tape_asm_parity par_i (
        .frame_i (in_data[6:0]),
        .even_i  (r_q.bcd),
        .ok_o    (par_ok)
    );

    tape_asm_merge mrg_i (
        .acc_i  (r_q.acc),
        .byte_i (in_data),
        .nine_i (r_q.nine),
        .slot_i (r_q.slot),
        .word_o (merged)
    );

    assign pad_init  = r_q.nine ? PAD9_INIT : PAD7_INIT;
    assign last_slot = r_q.nine ? LAST_SLOT9 : LAST_SLOT7;
    assign word_end  = in_last || (r_q.slot == last_slot);
    assign in_ready  = (r_q.st == ST_PACK) || (r_q.st == ST_DRAIN);

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        r_d.done  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_PACK;
                    r_d.addr = cfg_addr;
                    r_d.cnt  = cfg_count;
                    r_d.slot = 2'd0;
                    r_d.acc  = cfg_nine ? PAD9_INIT : PAD7_INIT;
                    r_d.bcd  = cfg_bcd;
                    r_d.nine = cfg_nine;
                    r_d.term = 1'b0;
                    r_d.par  = 1'b0;
                    r_d.lng  = 1'b0;
                    r_d.fill = 1'b0;
                    r_d.mark = 1'b0;
                end
            end
            ST_PACK: begin
                if (in_valid) begin
                    if (in_mark) begin
                        r_d.mark = 1'b1;
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.term = 1'b1;
                    end else if (!r_q.nine && !par_ok) begin
                        r_d.par  = 1'b1;
                        r_d.slot = 2'd0;
                        r_d.acc  = pad_init;
                        if (in_last) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                            r_d.term = 1'b1;
                        end else begin
                            r_d.st = ST_DRAIN;
                        end
                    end else if (word_end) begin
                        r_d.wr_en   = 1'b1;
                        r_d.wr_addr = r_q.addr;
                        r_d.wr_data = merged;
                        r_d.addr    = r_q.addr + 1'b1;
                        r_d.cnt     = r_q.cnt - 1'b1;
                        r_d.slot    = 2'd0;
                        r_d.acc     = pad_init;
                        if (r_q.cnt == CW'(1)) begin
                            if (!in_last) begin
                                r_d.lng = 1'b1;
                                r_d.st  = ST_DRAIN;
                            end else begin
                                r_d.st   = ST_IDLE;
                                r_d.done = 1'b1;
                                r_d.term = 1'b1;
                            end
                        end else if (in_last) begin
                            if (r_q.bcd) begin
                                r_d.st = ST_FILL;
                            end else begin
                                r_d.st   = ST_IDLE;
                                r_d.done = 1'b1;
                                r_d.term = 1'b1;
                            end
                        end
                    end else begin
                        r_d.acc  = merged;
                        r_d.slot = r_q.slot + 1'b1;
                    end
                end
            end
            ST_FILL: begin
                r_d.wr_en   = 1'b1;
                r_d.wr_addr = r_q.addr;
                r_d.wr_data = FILL_WORD;
                r_d.addr    = r_q.addr + 1'b1;
                r_d.cnt     = r_q.cnt - 1'b1;
                r_d.fill    = 1'b1;
                r_d.st      = ST_IDLE;
                r_d.done    = 1'b1;
                r_d.term    = 1'b1;
            end
            ST_DRAIN: begin
                if (in_valid && in_last) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.term = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en     = r_q.wr_en;
    assign wr_addr   = r_q.wr_addr;
    assign wr_data   = r_q.wr_data;
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign xfer_addr = r_q.addr;
    assign st_term   = r_q.term;
    assign st_parity = r_q.par;
    assign st_long   = r_q.lng;
    assign st_fill   = r_q.fill;
    assign st_mark   = r_q.mark;
endmodule

// File: rtl/tape_word_asm_chk.sv
module tape_word_asm_chk #(
    parameter int AW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          in_ready,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [23:0]   wr_data,
    input logic          st_fill,
    input logic          st_mark
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !in_ready);

    p_write_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(busy));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == AW'($past(wr_addr) + 1'b1)));

    p_fill_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_fill) |-> (wr_en && wr_data == 24'hF3CF3C && done));

    p_mark_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_mark) |-> (!wr_en && done));
endmodule

bind tape_word_asm tape_word_asm_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .st_fill  (st_fill),
    .st_mark  (st_mark)
);

// File: tb/tape_word_asm_tb_top.sv
module tape_word_asm_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int CW = 15;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [23:0]   data;
    } wr_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cfg_bcd = 1'b0;
    logic          cfg_nine = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          in_mark = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [23:0]   wr_data;
    logic          busy, done;
    logic [AW-1:0] xfer_addr;
    logic          st_term, st_parity, st_long, st_fill, st_mark;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    wr_item_t      exp_q[$];
    logic [7:0]    rec_q[$];
    bit            e_par, e_long, e_fill, e_mark;
    logic [AW-1:0] e_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_word_asm #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_bcd(cfg_bcd),
        .cfg_nine(cfg_nine), .cfg_addr(cfg_addr), .cfg_count(cfg_count),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_mark(in_mark), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
        .xfer_addr(xfer_addr), .st_term(st_term), .st_parity(st_parity),
        .st_long(st_long), .st_fill(st_fill), .st_mark(st_mark)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // seven-track character with parity for the chosen sense; bad flips it
    function automatic logic [7:0] mk7(input logic [5:0] d, input bit bcd,
                                       input bit bad, input bit hi);
        logic p;
        p = bcd ? (^d) : ~(^d);
        return {hi, p ^ bad, d};
    endfunction

    // scoreboard monitor: pops one expected write per observed write
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected write", {17'd0, wr_addr}, 32'd0);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                chk(wr_addr == e.addr, "R6 write address", {17'd0, wr_addr}, {17'd0, e.addr});
                chk(wr_data == e.data, "R1 R3 R4 R5 R9 write data", {8'd0, wr_data}, {8'd0, e.data});
            end
        end
    end

    // expected results derived from the requirements
    task automatic model(input bit bcd, input bit nine, input logic [AW-1:0] a0,
                         input logic [CW-1:0] c0, input bit mark);
        logic [23:0]   acc;
        logic [AW-1:0] a;
        logic [CW-1:0] c;
        int            slot;
        bit            stop;
        e_par = 0; e_long = 0; e_fill = 0; e_mark = 0;
        a = a0; c = c0; slot = 0; stop = 0;
        acc = nine ? 24'h000F3C : 24'hF3CF3C;
        if (mark) begin
            e_mark = 1;
        end else begin
            for (int i = 0; i < rec_q.size(); i++) begin
                logic [7:0] b;
                bit last;
                int sh;
                if (stop) break;
                b = rec_q[i];
                last = (i == rec_q.size() - 1);
                if (!nine && ((bcd && (^b[6:0])) || (!bcd && !(^b[6:0])))) begin
                    e_par = 1;
                    stop = 1;
                end else begin
                    if (nine) begin
                        sh = 16 - 8 * slot;
                        acc = (acc & ~(24'hFF << sh)) | ({16'd0, b} << sh);
                    end else begin
                        sh = 18 - 6 * slot;
                        acc = (acc & ~(24'h3F << sh)) | ({18'd0, b[5:0]} << sh);
                    end
                    if (last || slot == (nine ? 2 : 3)) begin
                        exp_q.push_back({a, acc});
                        a = a + 1'b1;
                        c = c - 1'b1;
                        slot = 0;
                        acc = nine ? 24'h000F3C : 24'hF3CF3C;
                        if (c == 0) begin
                            if (!last) e_long = 1;
                            stop = 1;
                        end else if (last) begin
                            if (bcd) begin
                                exp_q.push_back({a, 24'hF3CF3C});
                                a = a + 1'b1;
                                e_fill = 1;
                            end
                            stop = 1;
                        end
                    end else begin
                        slot++;
                    end
                end
            end
        end
        e_addr = a;
    endtask

    task automatic send(input logic [7:0] b, input bit last, input bit mark);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_last = last; in_mark = mark;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_mark = 1'b0;
    endtask

    task automatic run_case(input string tag, input bit bcd, input bit nine,
                            input logic [AW-1:0] a0, input logic [CW-1:0] c0,
                            input bit mark, input bit poke);
        int t;
        model(bcd, nine, a0, c0, mark);
        @(negedge clk);
        cfg_bcd = bcd; cfg_nine = nine; cfg_addr = a0; cfg_count = c0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mark) begin
            send(8'h00, 1'b1, 1'b1);
        end else begin
            for (int i = 0; i < rec_q.size(); i++) begin
                send(rec_q[i], i == rec_q.size() - 1, 1'b0);
                if (poke && i == 1) begin
                    // R11: start while busy must not redirect the transfer
                    @(negedge clk);
                    start = 1'b1; cfg_addr = 15'h1234; cfg_count = 15'd9; cfg_nine = ~nine;
                    @(negedge clk);
                    start = 1'b0; cfg_addr = a0; cfg_count = c0; cfg_nine = nine;
                end
            end
        end
        t = 0;
        while (!done && t < 50) begin
            @(negedge clk);
            t++;
        end
        chk(done, {tag, " R7 done pulse"}, {31'd0, done}, 32'd1);
        chk(!busy, {tag, " R7 busy clear"}, {31'd0, busy}, 32'd0);
        chk(st_term, {tag, " R7 terminate"}, {31'd0, st_term}, 32'd1);
        chk(xfer_addr == e_addr, {tag, " R7 next address"}, {17'd0, xfer_addr}, {17'd0, e_addr});
        chk(st_parity == e_par, {tag, " R2 parity flag"}, {31'd0, st_parity}, {31'd0, e_par});
        chk(st_long == e_long, {tag, " R8 long flag"}, {31'd0, st_long}, {31'd0, e_long});
        chk(st_fill == e_fill, {tag, " R9 fill flag"}, {31'd0, st_fill}, {31'd0, e_fill});
        chk(st_mark == e_mark, {tag, " R10 mark flag"}, {31'd0, st_mark}, {31'd0, e_mark});
        @(negedge clk);
        chk(!in_ready, {tag, " R11 idle not ready"}, {31'd0, in_ready}, 32'd0);
        chk(exp_q.size() == 0, {tag, " R6 writes outstanding"}, exp_q.size(), 32'd0);
        exp_q.delete();
        rec_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !done && !wr_en, "R12 reset outputs", {29'd0, busy, done, wr_en}, 32'd0);
        chk(!st_term && !st_parity && !st_long && !st_fill && !st_mark, "R12 reset flags",
            {27'd0, st_term, st_parity, st_long, st_fill, st_mark}, 32'd0);
        chk(!in_ready, "R11 ready low at reset", {31'd0, in_ready}, 32'd0);

        // R1: seven-track binary, exact end, start poked mid-record (R11)
        for (int i = 0; i < 8; i++) rec_q.push_back(mk7(6'(i + 1), 1'b0, 1'b0, 1'b0));
        run_case("c1_r1", 1'b0, 1'b0, 15'h0100, 15'd2, 1'b0, 1'b1);

        // R4: seven-track binary, short final word, no fill in binary
        for (int i = 0; i < 6; i++) rec_q.push_back(mk7(6'(8 + i), 1'b0, 1'b0, 1'b0));
        run_case("c2_r4", 1'b0, 1'b0, 15'h0200, 15'd5, 1'b0, 1'b0);

        // R9: seven-track BCD, short record gets padded word plus fill word
        for (int i = 0; i < 5; i++) rec_q.push_back(mk7(6'(17 + i), 1'b1, 1'b0, 1'b0));
        run_case("c3_r9", 1'b1, 1'b0, 15'h0300, 15'd4, 1'b0, 1'b0);

        // R3/R5: nine-track, one byte in final word
        for (int i = 0; i < 7; i++) rec_q.push_back(8'(8'hA0 + i));
        run_case("c4_r5", 1'b0, 1'b1, 15'h0400, 15'd5, 1'b0, 1'b0);

        // R5: nine-track, two bytes in final word
        for (int i = 0; i < 8; i++) rec_q.push_back(8'(8'h10 + 3 * i));
        run_case("c5_r5", 1'b0, 1'b1, 15'h0500, 15'd5, 1'b0, 1'b0);

        // R8: long block, count runs out with bytes left
        for (int i = 0; i < 9; i++) rec_q.push_back(8'(8'hC1 + i));
        run_case("c6_r8", 1'b0, 1'b1, 15'h0600, 15'd2, 1'b0, 1'b0);

        // R2: parity failure in the second word, binary sense
        for (int i = 0; i < 8; i++) rec_q.push_back(mk7(6'(30 + i), 1'b0, i == 5, 1'b0));
        run_case("c7_r2", 1'b0, 1'b0, 15'h0700, 15'd4, 1'b0, 1'b0);

        // R10: empty record
        run_case("c8_r10", 1'b0, 1'b0, 15'h0750, 15'd4, 1'b1, 1'b0);

        // R6: address wraps at the top of the 15-bit space
        for (int i = 0; i < 6; i++) rec_q.push_back(8'(8'h5A ^ i));
        run_case("c9_r6", 1'b0, 1'b1, 15'h7FFF, 15'd2, 1'b0, 1'b0);

        // R9: nine-track BCD, record ends on word boundary with count left
        for (int i = 0; i < 3; i++) rec_q.push_back(8'(8'h77 + i));
        run_case("c10_r9", 1'b1, 1'b1, 15'h0800, 15'd3, 1'b0, 1'b0);

        // R1/R2: BCD even sense, bit 7 set and ignored, count equals record
        for (int i = 0; i < 8; i++) rec_q.push_back(mk7(6'(50 + i), 1'b1, 1'b0, 1'b1));
        run_case("c11_r1", 1'b1, 1'b0, 15'h0900, 15'd2, 1'b0, 1'b0);

        // R2: BCD sense rejects a binary-parity character as last byte
        rec_q.push_back(mk7(6'd5, 1'b1, 1'b0, 1'b0));
        rec_q.push_back(mk7(6'd6, 1'b0, 1'b0, 1'b0));
        run_case("c12_r2", 1'b1, 1'b0, 15'h0A00, 15'd3, 1'b0, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule